// File: doc/BRIEF.md
# Anticipatory Frame-Sync Coast Window Generator

This block produces a hold-off ("coast") signal for a pixel-clock PLL in a video capture front end. It counts horizontal line strobes between consecutive vertical sync starts and keeps that figure as the expected frame length. In the following frame it raises coast a programmable number of lines before the vertical sync is expected. It keeps coast high for as long as vertical sync is high, and holds it for a programmable number of lines after vertical sync ends. This keeps the PLL from chasing the missing or malformed horizontal pulses that surround the vertical interval.

The line strobe `hs_tick` is a one-cycle pulse per line, already synchronized to `clk`. The vertical sync `vs_lvl` is a synchronized level. The block finds its rising and falling edges itself by comparing it with the previous cycle. With `ext_en` low, the block falls back to passing vertical sync straight through as coast. Line index means the number of `hs_tick` pulses since the latest vertical sync rise. A pulse in the same cycle as the rise counts as line 1 of the new frame.

Top module: `coast_window_gen`

## Requirements
- R1: In the cycle after a vertical sync rise, `frame_lines` holds the number of `hs_tick` pulses seen since the previous rise, and it keeps that value until the next rise.
- R2: `frame_ok` is 0 after reset and stays 0 through the first vertical sync rise. It becomes 1 after a rise that closes a complete frame. While `frame_ok` is 0, no early coast is produced.
- R3: The line index saturates at 2047. An `hs_tick` arriving while it is already 2047 clears `frame_ok`. The next rise latches 2047 into `frame_lines` and leaves `frame_ok` at 0. `frame_ok` returns only after one more complete frame.
- R4: With `ext_en`=1 and `frame_ok`=1, coast is high from the cycle after the line index reaches `frame_lines - pre_lines` until the next vertical sync rise.
- R5: If `pre_lines` is at least `frame_lines`, the threshold is 0, so coast stays high for the whole frame once `frame_ok` is 1.
- R6: With `ext_en`=1 and `post_lines`=N>0, coast stays high after vertical sync falls through the cycle of the N-th `hs_tick` that follows the falling cycle. It goes low in the next cycle unless R4 holds. A pulse in the falling cycle itself is not counted.
- R7: With `post_lines`=0, coast goes low in the same cycle that vertical sync goes low, unless R4 holds.
- R8: Coast is high in every cycle in which `vs_lvl` is high, whatever the settings.
- R9: With `ext_en`=0, coast equals `vs_lvl` in every cycle.
- R10: After reset, coast is 0 (with `vs_lvl` low), `frame_lines` is 0 and `frame_ok` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hs_tick | input | 1 | One-cycle strobe per line |
| vs_lvl | input | 1 | Synchronized vertical sync level, active high |
| ext_en | input | 1 | 1: early and late extension active; 0: coast follows vertical sync |
| pre_lines | input | 8 | Lines of coast before the expected vertical sync |
| post_lines | input | 8 | Lines of coast after vertical sync falls |
| coast | output | 1 | PLL hold-off |
| frame_lines | output | 11 | Line count of the last frame |
| frame_ok | output | 1 | `frame_lines` comes from a complete frame |

## Verification
The bench is driven through a table of frame lengths and settings. The cases are an ordinary early-and-late window, both extensions at zero, a pre-coast larger than the frame, a disabled extension, and one-line extensions. Each case runs several frames, so the bench sees the first partial frame without early coast and the switch between frame lengths. Coast is checked after every line strobe and on both vertical sync edges. This separates an off-by-one in the threshold or the post count from a late release at the falling edge. A directed run of more than 2047 lines without vertical sync covers saturation and the two-rise recovery.

// File: rtl/coast_window_pkg.sv
// Package: shared types for the coast window generator.
// Assumes nothing beyond the synthesizable subset.
package coast_window_pkg;

    // Edge events of the vertical sync level, one cycle wide each.
    typedef struct packed {
        logic rise;
        logic fall;
    } vs_edge_t;

    // Default widths: an 11-bit line index and 8-bit extension settings.
    localparam int unsigned DEF_LINE_W = 11;
    localparam int unsigned DEF_SET_W  = 8;

endpackage

// File: rtl/cwg_vs_edge.sv
// Module: cwg_vs_edge
// Finds the rising and falling edges of the synchronized vertical sync level.
// Assumes vs_lvl is already synchronous to clk. The edges are combinational
// against the previous-cycle sample, so each is reported in the cycle in
// which the level changes.
module cwg_vs_edge
    import coast_window_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     vs_lvl,
    output vs_edge_t vs_edge
);

    logic vs_q;

    // Holds the vertical sync level seen in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) vs_q <= 1'b0;
        else        vs_q <= vs_lvl;
    end

    // Reports the level changes as one-cycle events.
    always_comb begin
        vs_edge.rise = vs_lvl & ~vs_q;
        vs_edge.fall = ~vs_lvl & vs_q;
    end

    assert_edges_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(vs_edge.rise && vs_edge.fall));

endmodule

// File: rtl/cwg_line_meter.sv
// Module: cwg_line_meter
// Counts line strobes since the latest vertical sync rise. At each rise it
// latches that count as the frame length. It tracks whether the latched
// length comes from a complete, unsaturated frame.
// Assumes one hs_tick per line. A tick that coincides with a rise counts as
// line 1 of the new frame.
module cwg_line_meter
    import coast_window_pkg::*;
#(
    parameter int unsigned LINE_W = DEF_LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_tick,
    input  vs_edge_t          vs_edge,
    output logic [LINE_W-1:0] line_idx,
    output logic [LINE_W-1:0] meas_lines,
    output logic              meas_ok
);

    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};
    localparam logic [LINE_W-1:0] LINE_ONE = {{(LINE_W-1){1'b0}}, 1'b1};

    logic armed;    // a rise has been seen since reset or saturation
    logic at_max;

    assign at_max = (line_idx == LINE_MAX);

    // Advances the line index, restarting it on every vertical sync rise.
    always_ff @(posedge clk) begin
        if (!rst_n)            line_idx <= '0;
        else if (vs_edge.rise) line_idx <= hs_tick ? LINE_ONE : '0;
        else if (hs_tick && !at_max) line_idx <= line_idx + LINE_ONE;
    end

    // Latches the frame length at each rise.
    always_ff @(posedge clk) begin
        if (!rst_n)            meas_lines <= '0;
        else if (vs_edge.rise) meas_lines <= line_idx;
    end

    // Tracks whether a full frame has been seen; saturation drops it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            meas_ok <= 1'b0;
        end else if (vs_edge.rise) begin
            armed   <= 1'b1;
            meas_ok <= armed;
        end else if (hs_tick && at_max) begin
            armed   <= 1'b0;
            meas_ok <= 1'b0;
        end
    end

    assert_latch_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vs_edge.rise |=> (meas_lines == $past(line_idx)));

    assert_ok_only_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(meas_ok) |-> $past(vs_edge.rise));

    assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && hs_tick && !vs_edge.rise) |=> (line_idx == LINE_MAX && !meas_ok));

endmodule

// File: rtl/cwg_pre_window.sv
// Module: cwg_pre_window
// Decides whether the early part of the coast window is open. It compares
// the current line index with the latched frame length minus the pre-coast
// setting. The difference is floored at zero.
// Assumes meas_ok qualifies meas_lines. The result is combinational.
module cwg_pre_window
    import coast_window_pkg::*;
#(
    parameter int unsigned LINE_W = DEF_LINE_W,
    parameter int unsigned SET_W  = DEF_SET_W
) (
    input  logic              ext_en,
    input  logic              meas_ok,
    input  logic [LINE_W-1:0] line_idx,
    input  logic [LINE_W-1:0] meas_lines,
    input  logic [SET_W-1:0]  pre_lines,
    output logic              pre_hit
);

    logic [LINE_W-1:0] pre_ext;
    logic [LINE_W-1:0] threshold;

    // Widens the setting and forms the floored threshold line.
    always_comb begin
        pre_ext   = LINE_W'(pre_lines);
        threshold = (meas_lines > pre_ext) ? (meas_lines - pre_ext) : '0;
    end

    // Opens the early window once the line index reaches the threshold.
    always_comb begin
        pre_hit = ext_en && meas_ok && (line_idx >= threshold);
    end

endmodule

// File: rtl/cwg_post_hold.sv
// Module: cwg_post_hold
// Holds coast after vertical sync falls, for a set number of line strobes.
// Assumes the setting is sampled live. A strobe in the falling cycle is not
// counted. A rise ends the hold at once.
module cwg_post_hold
    import coast_window_pkg::*;
#(
    parameter int unsigned SET_W = DEF_SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_tick,
    input  vs_edge_t         vs_edge,
    input  logic             ext_en,
    input  logic [SET_W-1:0] post_lines,
    output logic             post_busy,
    output logic             post_start
);

    logic [SET_W-1:0] cnt;
    logic [SET_W:0]   cnt_next;

    assign cnt_next   = {1'b0, cnt} + 1'b1;
    assign post_start = vs_edge.fall && ext_en && (post_lines != '0);

    // Starts, counts and ends the late hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_busy <= 1'b0;
            cnt       <= '0;
        end else if (vs_edge.rise) begin
            post_busy <= 1'b0;
            cnt       <= '0;
        end else if (post_start) begin
            post_busy <= 1'b1;
            cnt       <= '0;
        end else if (post_busy && hs_tick) begin
            cnt <= cnt_next[SET_W-1:0];
            if (cnt_next >= {1'b0, post_lines}) post_busy <= 1'b0;
        end
    end

    assert_zero_post_no_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_edge.fall && post_lines == '0 && !post_busy) |=> !post_busy);

    assert_release_on_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(post_busy) |-> ($past(hs_tick) || $past(vs_edge.rise)));

endmodule

// File: rtl/coast_window_gen.sv
// Module: coast_window_gen (top)
// Builds the PLL coast signal. It combines the vertical sync level, the
// early window predicted from the last measured frame length, and the late
// hold after vertical sync ends.
// Assumes hs_tick and vs_lvl are synchronous to clk. Coast responds to
// vs_lvl in the same cycle.
module coast_window_gen
    import coast_window_pkg::*;
#(
    parameter int unsigned LINE_W = DEF_LINE_W,
    parameter int unsigned SET_W  = DEF_SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_tick,
    input  logic              vs_lvl,
    input  logic              ext_en,
    input  logic [SET_W-1:0]  pre_lines,
    input  logic [SET_W-1:0]  post_lines,
    output logic              coast,
    output logic [LINE_W-1:0] frame_lines,
    output logic              frame_ok
);

    vs_edge_t          vs_edge;
    logic [LINE_W-1:0] line_idx;
    logic              pre_hit;
    logic              post_busy;
    logic              post_start;

    cwg_vs_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .vs_lvl  (vs_lvl),
        .vs_edge (vs_edge)
    );

    cwg_line_meter #(.LINE_W(LINE_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_tick    (hs_tick),
        .vs_edge    (vs_edge),
        .line_idx   (line_idx),
        .meas_lines (frame_lines),
        .meas_ok    (frame_ok)
    );

    cwg_pre_window #(.LINE_W(LINE_W), .SET_W(SET_W)) u_pre (
        .ext_en     (ext_en),
        .meas_ok    (frame_ok),
        .line_idx   (line_idx),
        .meas_lines (frame_lines),
        .pre_lines  (pre_lines),
        .pre_hit    (pre_hit)
    );

    cwg_post_hold #(.SET_W(SET_W)) u_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_tick    (hs_tick),
        .vs_edge    (vs_edge),
        .ext_en     (ext_en),
        .post_lines (post_lines),
        .post_busy  (post_busy),
        .post_start (post_start)
    );

    // Merges the sync level with the early and late extensions.
    always_comb begin
        coast = vs_lvl || (ext_en && (pre_hit || post_busy || post_start));
    end

    assert_no_early_without_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |-> !pre_hit);

    assert_coast_covers_vs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vs_lvl |-> coast);

    assert_follow_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |-> (coast == vs_lvl));

endmodule

// File: tb/coast_window_gen_test.sv
module coast_window_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs_tick = 1'b0;
    logic        vs_lvl = 1'b0;
    logic        ext_en = 1'b0;
    logic [7:0]  pre_lines = '0;
    logic [7:0]  post_lines = '0;
    logic        coast;
    logic [10:0] frame_lines;
    logic        frame_ok;

    int checks = 0;
    int errors = 0;

    // Bench model state, built from the requirements.
    int  m_line  = 0;
    int  m_meas  = 0;
    bit  m_valid = 0;
    bit  m_armed = 0;
    bit  m_pact  = 0;
    int  m_pcnt  = 0;

    // Vector: [27:17] frame lines, [16:9] pre, [8:1] post, [0] enable.
    localparam int NVEC = 6;
    localparam logic [27:0] VEC [NVEC] = '{
        {11'd20, 8'd4,  8'd2, 1'b1},
        {11'd20, 8'd0,  8'd0, 1'b1},
        {11'd12, 8'd30, 8'd5, 1'b1},
        {11'd16, 8'd5,  8'd3, 1'b0},
        {11'd25, 8'd1,  8'd1, 1'b1},
        {11'd18, 8'd18, 8'd0, 1'b1}
    };

    coast_window_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs_tick     (hs_tick),
        .vs_lvl      (vs_lvl),
        .ext_en      (ext_en),
        .pre_lines   (pre_lines),
        .post_lines  (post_lines),
        .coast       (coast),
        .frame_lines (frame_lines),
        .frame_ok    (frame_ok)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_prehit();
        int thr;
        thr = (m_meas > pre_lines) ? m_meas - pre_lines : 0;
        return ext_en && m_valid && (m_line >= thr);
    endfunction

    function automatic bit m_coast();
        return vs_lvl || (ext_en && (m_prehit() || m_pact));
    endfunction

    task automatic tick_hs(input string req);
        @(negedge clk); hs_tick = 1'b1;
        @(negedge clk); hs_tick = 1'b0;
        if (m_line == 2047) begin m_valid = 0; m_armed = 0; end
        else m_line++;
        if (m_pact) begin
            m_pcnt++;
            if (m_pcnt >= post_lines) m_pact = 0;
        end
        check(req, coast, m_coast());
    endtask

    task automatic set_vs(input bit v);
        @(negedge clk); vs_lvl = v;
        #1;
        if (v) check("R8 coast on vsync rise", coast, 1);
        else   check("R7 coast in falling cycle", coast,
                     ext_en && (post_lines != 0 || m_prehit()));
        @(negedge clk);
        if (v) begin
            m_meas = m_line; m_valid = m_armed; m_armed = 1; m_line = 0; m_pact = 0;
            check("R1 frame_lines", frame_lines, m_meas);
            check("R2 frame_ok", frame_ok, m_valid);
        end else begin
            m_pact = ext_en && (post_lines != 0); m_pcnt = 0;
        end
        check(v ? "R8 coast in vsync" : "R6 coast after fall", coast, m_coast());
    endtask

    task automatic run_frame(input int n);
        set_vs(1);
        for (int i = 0; i < n; i++) begin
            tick_hs(ext_en ? "R4 R5 R6 coast per line" : "R9 coast follows vsync");
            if (i == 2) set_vs(0);
        end
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 coast after reset", coast, 0);
        check("R10 frame_lines after reset", frame_lines, 0);
        check("R10 frame_ok after reset", frame_ok, 0);

        // Table-driven frames.
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            ext_en     = VEC[v][0];
            post_lines = VEC[v][8:1];
            pre_lines  = VEC[v][16:9];
            for (int f = 0; f < 3; f++) run_frame(int'(VEC[v][27:17]));
        end

        // R5: pre larger than the frame keeps coast high all frame long.
        ext_en = 1'b1; pre_lines = 8'd200; post_lines = 8'd0;
        run_frame(18);
        check("R5 floor keeps coast high", coast, 1);

        // R3: saturation without vertical sync.
        for (int i = 0; i < 2050; i++) tick_hs("R3 coast while counting");
        check("R3 frame_ok cleared on saturation", frame_ok, 0);
        check("R3 no early coast after saturation", coast, 0);
        set_vs(1);
        check("R3 saturated length latched", frame_lines, 2047);
        check("R3 frame_ok stays low", frame_ok, 0);
        set_vs(0);
        for (int i = 0; i < 9; i++) tick_hs("R3 recovery frame");
        set_vs(1);
        check("R3 recovered frame_ok", frame_ok, 1);
        check("R3 recovered frame_lines", frame_lines, 9);
        set_vs(0);

        // R9: extension off during a later frame.
        ext_en = 1'b0; post_lines = 8'd7;
        tick_hs("R9 off after fall");
        check("R9 coast low with vsync low", coast, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule